// File: doc/BRIEF.md
# Triangular Spread-Spectrum Fraction Modulator

This block sits in front of the fractional word of a fractional-N divider. It adds a slow triangular offset to that word, so the synthesized clock sweeps in frequency and its spectral energy spreads. A reference-rate tick paces the sweep. A 4-bit rate code divides the tick into triangle steps, so the modulation frequency falls in inverse proportion to the code. A 5-bit depth code sets the size of each step and so sets the peak deviation linearly. The offset is available as a signed output, and the modulated fraction (base plus offset) is also produced.

Two spread shapes are supported. Center spread swings the fraction symmetrically above and below nominal. Down spread swings it only below nominal, across the full depth. The sweep runs only while delta-sigma (fractional) mode is on and bypass is off. Otherwise the offset is held at zero and the base fraction passes through unchanged. Configuration is sampled while idle and again each time a period finishes, which is where the offset is zero, so the waveform never jumps. Leaving bypass always restarts the sweep at zero in its first phase.

With Q = `QSTEPS` steps per quarter period and s = depth × `STEP_LSB`, a period is 4·Q steps. Each step takes max(rate,1) ticks.

Top module: `ssc_tri_mod`

## Requirements
- R1: While reset is asserted and right after it, `ss_offset` is 0 and `frac_out` equals `frac_base`.
- R2: With `dsm_en` low (integer mode), `ss_offset` is 0 at every tick, whatever the other controls are.
- R3: With `ss_bypass` high, `ss_offset` is 0 and `frac_out` equals `frac_base`.
- R4: A triangle step happens once every `rate_code` ticks. A code of 0 behaves as 1. A full period is 4·Q·max(rate,1) ticks.
- R5: Each step moves the offset by s = `depth_code` × `STEP_LSB`. A depth code of 0 keeps the offset at 0.
- R6: Center spread (`spread_down` = 0) rises from 0 to +Q·s, falls to −Q·s, then returns to 0, and never leaves that range.
- R7: Down spread (`spread_down` = 1) falls from 0 to −2·Q·s, then returns to 0, and is never positive.
- R8: Changes to rate, depth or spread type made while the sweep runs take effect only when the current period ends at offset 0.
- R9: When bypass is left, the sweep restarts at offset 0. Its first step in center spread is upward, using the configuration present in the last idle cycle.
- R10: `frac_out` equals `frac_base` plus the sign-extended `ss_offset`, modulo 2^`FRAC_W`. `ss_offset` is two's complement.
- R11: `ss_offset` is registered. It changes only on the clock edge that ends a cycle with `ref_tick` high, and it holds its value through cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Reference-rate pacing strobe, one cycle wide |
| dsm_en | input | 1 | Fractional (delta-sigma) mode active |
| ss_bypass | input | 1 | Holds the offset at zero and restarts the sweep |
| spread_down | input | 1 | 0 = center spread, 1 = down spread |
| rate_code | input | 4 | Ticks per triangle step (0 acts as 1) |
| depth_code | input | 5 | Step size in units of `STEP_LSB` |
| frac_base | input | FRAC_W | Nominal fractional word |
| ss_offset | output | OFF_W | Signed triangular offset |
| frac_out | output | FRAC_W | Modulated fractional word |

## Verification
The offset register updates on the edge that ends a tick cycle. Its new value is therefore due exactly one clock after the cycle in which the driver applies a tick, bypass or enable change. With the default unregistered output sum, `frac_out` follows the offset with no further delay. The driver applies stimulus at the falling edge and computes, from the requirement formulas, the value the offset must take at the next rising edge; it queues that value together with the tagged requirement. The monitor removes one entry per cycle and compares it one time unit after the rising edge, so every comparison lands on the cycle in which that result first appears.

// File: rtl/ssc_pkg.sv
package ssc_pkg;
   localparam int RATE_W  = 4;
   localparam int DEPTH_W = 5;

   typedef struct packed {
      logic               down;
      logic [RATE_W-1:0]  rate;
      logic [DEPTH_W-1:0] depth;
   } ssc_cfg_t;

   typedef enum logic {
      RAMP_DN = 1'b0,
      RAMP_UP = 1'b1
   } ramp_dir_e;

   // direction of the step taken from phase position ph
   function automatic ramp_dir_e ramp_dir(input int unsigned ph,
                                          input int unsigned q,
                                          input logic        down);
      if (down) return (ph < 2*q) ? RAMP_DN : RAMP_UP;
      if ((ph < q) || (ph >= 3*q)) return RAMP_UP;
      return RAMP_DN;
   endfunction
endpackage

// File: rtl/ssc_step_gen.sv
module ssc_step_gen #(
   parameter int RATE_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              tick,
   input  logic [RATE_W-1:0] rate,
   output logic              step
);
   logic [RATE_W-1:0] cnt_q;
   logic [RATE_W-1:0] lim;

   always_comb begin
      lim  = (rate == '0) ? '0 : rate - 1'b1;
      step = run & tick & (cnt_q == lim);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (!run)    cnt_q <= '0;
      else if (tick)    cnt_q <= step ? '0 : cnt_q + 1'b1;
   end
endmodule

// File: rtl/ssc_phase_ctr.sv
module ssc_phase_ctr
   import ssc_pkg::*;
#(
   parameter int QSTEPS = 8,
   parameter int PH_W   = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run,
   input  logic            step,
   input  logic            down,
   output ramp_dir_e       dir,
   output logic            wrap
);
   localparam int LAST = 4*QSTEPS - 1;

   logic [PH_W-1:0] ph_q;

   always_comb begin
      dir  = ramp_dir(32'(ph_q), QSTEPS, down);
      wrap = step && (ph_q == PH_W'(LAST));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ph_q <= '0;
      else if (!run)  ph_q <= '0;
      else if (step)  ph_q <= wrap ? '0 : ph_q + 1'b1;
   end
endmodule

// File: rtl/ssc_tri_acc.sv
module ssc_tri_acc
   import ssc_pkg::*;
#(
   parameter int OFF_W    = 16,
   parameter int QSTEPS   = 8,
   parameter int STEP_LSB = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic                      step,
   input  ramp_dir_e                 dir,
   input  logic                      down,
   input  logic [DEPTH_W-1:0]        depth,
   output logic signed [OFF_W-1:0]   offset
);
   localparam int AW = OFF_W + 2;

   logic signed [AW-1:0] stepsz, hi, lo, cur, nxt;

   always_comb begin
      stepsz = $signed(AW'(depth)) * $signed(AW'(STEP_LSB));
      hi     = down ? '0 : stepsz * $signed(AW'(QSTEPS));
      lo     = down ? -(stepsz * $signed(AW'(2*QSTEPS)))
                    : -(stepsz * $signed(AW'(QSTEPS)));
      cur    = AW'(offset);
      nxt    = (dir == RAMP_UP) ? cur + stepsz : cur - stepsz;
      if (nxt > hi) nxt = hi;
      if (nxt < lo) nxt = lo;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     offset <= '0;
      else if (!run)  offset <= '0;
      else if (step)  offset <= nxt[OFF_W-1:0];
   end
endmodule

// File: rtl/ssc_tri_mod.sv
module ssc_tri_mod
   import ssc_pkg::*;
#(
   parameter int FRAC_W       = 24,
   parameter int OFF_W        = 16,
   parameter int QSTEPS       = 8,
   parameter int STEP_LSB     = 16,
   parameter bit FRAC_OUT_REG = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     ref_tick,
   input  logic                     dsm_en,
   input  logic                     ss_bypass,
   input  logic                     spread_down,
   input  logic [3:0]               rate_code,
   input  logic [4:0]               depth_code,
   input  logic [FRAC_W-1:0]        frac_base,
   output logic signed [OFF_W-1:0]  ss_offset,
   output logic [FRAC_W-1:0]        frac_out
);
   localparam int PH_W      = $clog2(4*QSTEPS);
   localparam int MAX_SWING = 2*QSTEPS*((1 << DEPTH_W) - 1)*STEP_LSB;

   if (QSTEPS < 1)                      begin : g_bad_q   $error("QSTEPS must be at least 1"); end
   if (MAX_SWING >= (1 << (OFF_W-1)))   begin : g_bad_off $error("OFF_W too narrow for swing"); end
   if (OFF_W > FRAC_W)                  begin : g_bad_frac $error("OFF_W exceeds FRAC_W"); end

   logic      run;
   logic      step;
   logic      wrap;
   ramp_dir_e dir;
   ssc_cfg_t  cfg_in, cfg_q;

   always_comb begin
      run    = dsm_en & ~ss_bypass;
      cfg_in = '{down: spread_down, rate: rate_code, depth: depth_code};
   end

   // configuration follows the inputs while idle, else only at period end
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cfg_q <= '0;
      else if (!run || wrap)  cfg_q <= cfg_in;
   end

   ssc_step_gen #(.RATE_W(RATE_W)) u_step (
      .clk(clk), .rst_n(rst_n), .run(run), .tick(ref_tick),
      .rate(cfg_q.rate), .step(step)
   );

   ssc_phase_ctr #(.QSTEPS(QSTEPS), .PH_W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .run(run), .step(step),
      .down(cfg_q.down), .dir(dir), .wrap(wrap)
   );

   ssc_tri_acc #(.OFF_W(OFF_W), .QSTEPS(QSTEPS), .STEP_LSB(STEP_LSB)) u_acc (
      .clk(clk), .rst_n(rst_n), .run(run), .step(step), .dir(dir),
      .down(cfg_q.down), .depth(cfg_q.depth), .offset(ss_offset)
   );

   logic [FRAC_W-1:0] sum;
   always_comb sum = frac_base + FRAC_W'(ss_offset);

   if (FRAC_OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) frac_out <= '0;
         else        frac_out <= sum;
      end
   end else begin : g_out_comb
      always_comb frac_out = sum;
   end
endmodule

// File: rtl/ssc_tri_mod_chk.sv
module ssc_tri_mod_chk #(
   parameter int OFF_W    = 16,
   parameter int QSTEPS   = 8,
   parameter int STEP_LSB = 16
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    ref_tick,
   input logic                    dsm_en,
   input logic                    ss_bypass,
   input logic                    cfg_down,
   input logic signed [OFF_W-1:0] offset
);
   localparam int MAX_STEP = 31*STEP_LSB;
   localparam int HI_LIM   = QSTEPS*MAX_STEP;
   localparam int LO_LIM   = -2*QSTEPS*MAX_STEP;

   logic signed [OFF_W:0] prev_off, delta;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_off <= '0;
      else        prev_off <= (OFF_W+1)'(offset);
   end
   always_comb delta = (OFF_W+1)'(offset) - prev_off;

   // R2 R3
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!dsm_en || ss_bypass) |=> (offset == '0));

   // R11
   hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsm_en && !ss_bypass && !ref_tick) |=> $stable(offset));

   // R7
   down_nonpos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_down |-> (offset <= 0));

   // R6
   swing_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(offset) <= HI_LIM) && (int'(offset) >= LO_LIM));

   // R5
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsm_en && !ss_bypass) |=> ((int'(delta) <= MAX_STEP) && (int'(delta) >= -MAX_STEP)));
endmodule

bind ssc_tri_mod ssc_tri_mod_chk #(.OFF_W(OFF_W), .QSTEPS(QSTEPS), .STEP_LSB(STEP_LSB)) u_chk (
   .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .dsm_en(dsm_en),
   .ss_bypass(ss_bypass), .cfg_down(cfg_q.down), .offset(ss_offset)
);

// File: tb/sim_ssc_tri_mod.sv
module sim_ssc_tri_mod;
   localparam int PERIOD = 10;
   localparam int FW = 24, OW = 16, Q = 8, LSB = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ref_tick = 1'b0, dsm_en = 1'b0, ss_bypass = 1'b1, spread_down = 1'b0;
   logic [3:0] rate_code = '0;
   logic [4:0] depth_code = '0;
   logic [FW-1:0] frac_base = '0;
   logic signed [OW-1:0] ss_offset;
   logic [FW-1:0] frac_out;

   ssc_tri_mod u0 (.*);

   always #(PERIOD/2) clk = ~clk;

   typedef struct { int off; logic [FW-1:0] frac; string req; } exp_t;
   exp_t sbq[$];

   int n_chk = 0, n_fail = 0;
   int obs_max = 0, obs_min = 0;
   bit done = 1'b0;

   // stimulus values applied at the next driven cycle
   bit t_dsm = 0, t_byp = 1, t_down = 0;
   int t_rate = 0, t_depth = 0, t_base = 0;

   // independent model state
   int m_tc = 0, m_n = 0, m_rate = 0, m_depth = 0;
   bit m_down = 0;

   function automatic int tri_val(int n, int s, bit dn);
      if (dn) return (n <= 2*Q) ? -n*s : (n - 4*Q)*s;
      if (n <= Q)   return n*s;
      if (n <= 3*Q) return (2*Q - n)*s;
      return (n - 4*Q)*s;
   endfunction

   task automatic check(bit ok, string rq, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
      end
   endtask

   task automatic drive(bit tk, string rq);
      exp_t e;
      int ex;
      @(negedge clk);
      ref_tick = tk; dsm_en = t_dsm; ss_bypass = t_byp; spread_down = t_down;
      rate_code = 4'(t_rate); depth_code = 5'(t_depth); frac_base = FW'(t_base);
      if (!t_dsm || t_byp) begin
         m_tc = 0; m_n = 0; m_rate = t_rate; m_depth = t_depth; m_down = t_down;
      end else if (tk) begin
         m_tc++;
         if (m_tc >= ((m_rate == 0) ? 1 : m_rate)) begin
            m_tc = 0; m_n++;
            if (m_n == 4*Q) begin
               m_n = 0; m_rate = t_rate; m_depth = t_depth; m_down = t_down;
            end
         end
      end
      ex = tri_val(m_n, m_depth*LSB, m_down);
      e.off = ex; e.frac = FW'(t_base + ex); e.req = rq;
      sbq.push_back(e);
   endtask

   // monitor: one expected item per cycle, sampled after the edge
   initial begin
      exp_t e;
      forever begin
         @(posedge clk); #1;
         if (sbq.size() > 0) begin
            e = sbq.pop_front();
            check(int'(ss_offset) == e.off, e.req, int'(ss_offset), e.off);
            check(frac_out == e.frac, {e.req, "/R10"}, int'(frac_out), int'(e.frac));
            if (int'(ss_offset) > obs_max) obs_max = int'(ss_offset);
            if (int'(ss_offset) < obs_min) obs_min = int'(ss_offset);
         end
      end
   end

   initial begin
      #(PERIOD*200000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic clear_peaks();
      @(negedge clk); obs_max = 0; obs_min = 0;
   endtask

   initial begin
      frac_base = 24'h123456;
      repeat (3) @(negedge clk);
      // R1 during reset
      check(ss_offset == '0, "R1", int'(ss_offset), 0);
      check(frac_out == 24'h123456, "R1", int'(frac_out), 24'h123456);
      rst_n = 1'b1;
      t_base = 24'h123456; t_depth = 31; t_rate = 1;
      repeat (3) drive(1, "R1");

      // R2 integer mode never spreads
      t_dsm = 0; t_byp = 0;
      repeat (40) drive(1, "R2");

      // R3 bypass holds zero
      t_dsm = 1; t_byp = 1; t_base = 24'h00ABCD;
      repeat (20) drive(1, "R3");

      // R6 R9 center, depth 31, rate 1
      clear_peaks();
      t_byp = 0; t_down = 0;
      repeat (2*4*Q + 5) drive(1, "R6");
      check(obs_max == Q*31*LSB, "R6", obs_max, Q*31*LSB);
      check(obs_min == -Q*31*LSB, "R6", obs_min, -Q*31*LSB);

      // R9 restart from bypass at zero, first step upward
      t_byp = 1; drive(1, "R3");
      t_byp = 0; t_depth = 3;
      repeat (4) drive(1, "R9");

      // R7 R4 down spread, rate 2, tick every other cycle
      t_byp = 1; t_down = 1; t_depth = 5; t_rate = 2; drive(0, "R3");
      clear_peaks();
      t_byp = 0;
      for (int i = 0; i < 4*Q*2 + 6; i++) begin drive(1, "R7"); drive(0, "R4"); end
      check(obs_max == 0, "R7", obs_max, 0);
      check(obs_min == -2*Q*5*LSB, "R7", obs_min, -2*Q*5*LSB);

      // R4 rate code 0 acts as 1; rate 3 slower sweep
      t_byp = 1; t_down = 0; t_rate = 0; t_depth = 2; drive(1, "R3");
      t_byp = 0;
      repeat (40) drive(1, "R4");
      t_byp = 1; t_rate = 3; drive(1, "R3");
      t_byp = 0;
      repeat (100) drive(1, "R4");

      // R5 depth 0 stays at zero
      t_byp = 1; t_rate = 1; t_depth = 0; drive(1, "R3");
      clear_peaks();
      t_byp = 0;
      repeat (40) drive(1, "R5");
      check(obs_max == 0 && obs_min == 0, "R5", obs_max - obs_min, 0);

      // R8 mid-period change takes effect only at period end
      t_byp = 1; t_depth = 10; t_down = 0; drive(1, "R3");
      t_byp = 0;
      repeat (20) drive(1, "R8");
      t_depth = 20; t_down = 1; t_rate = 2;
      repeat (150) drive(1, "R8");

      // R10 R11 wraparound of the sum, irregular ticks
      t_byp = 1; t_base = 5; t_rate = 1; t_depth = 7; t_down = 1; drive(1, "R3");
      t_byp = 0;
      for (int i = 0; i < 60; i++) drive(((i % 3) == 0) || ((i % 5) == 1), "R11");
      repeat (10) drive(0, "R11");

      @(negedge clk); @(negedge clk);
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule